// File: doc/BRIEF.md
# RC5 Subkey Mixing Engine

This block turns a 128-bit secret key into the 26-word subkey table used by RC5 with 32-bit words, 12 rounds and a 16-byte key. A start pulse copies the key into four 32-bit working words and resets the subkey table to its fixed seed sequence. The engine then runs the 78 iterations of the key-mixing loop, which updates one subkey word and one key word per iteration. Every update involves rotations, and one of those rotations depends on the data.

The engine is sequential. Each mixing iteration takes three clocks: one computes the new A, one computes the new B, and one writes both back and advances the two indices. While it runs, busy is high. When it finishes, done goes high and stays high until the next accepted start. The finished table is read through a combinational read port. A key cipher would use that port to fetch the subkeys for encryption.

Top module: `rc5_key_mixer`

## Requirements
- R1: After reset, busy_o and done_o are 0 and the table reads as the seed sequence: word 0 is 0xB7E15163 and each next word is the previous one plus 0x9E3779B9, modulo 2^32.
- R2: A start_i seen at a rising edge while busy_o is 0 makes busy_o high from that edge on. The key is packed little-endian: key byte b is key_i[8b+7:8b], and key word w is key_i[32w+31:32w].
- R3: On completion the table holds the result of 78 mixing iterations with A, B, i and j starting at 0. Each iteration sets A = S[i] = rotl(S[i]+A+B, 3), then B = L[j] = rotl(L[j]+A+B, A+B) using the new A. After that, i advances modulo 26 and j advances modulo 4.
- R4: Every rotate amount uses only the low 5 bits of its operand, and every addition wraps modulo 2^32.
- R5: busy_o stays high for exactly 234 cycles, which is 3 clocks per iteration.
- R6: done_o rises on the edge where busy_o falls. It then holds until the next accepted start, and it is 0 from that start's edge on.
- R7: A start_i seen while busy_o is 1 is ignored. The run in progress keeps its key and its timing.
- R8: busy_o and done_o are never 1 at the same time.
- R9: rd_data_o shows table word rd_addr_i in the same cycle. Addresses 26 to 31 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a run when idle |
| key_i | input | 128 | Secret key, byte 0 in bits 7:0 |
| busy_o | output | 1 | Mixing in progress |
| done_o | output | 1 | Table valid, held until next start |
| rd_addr_i | input | 5 | Table read index |
| rd_data_o | output | 32 | Table word at rd_addr_i |

## Verification
The hardest case to reach from the ports is a start that arrives in the middle of a run. The outputs stay the same when it is ignored; the only evidence would be a corrupted table 234 cycles later. The bench therefore pulses start with a different key partway through a run. It then checks that busy still lasts exactly 234 cycles and that every table word matches the first key. Rotate amounts of 0 and 31 come only from particular data. To cover them, the bench sweeps a family of keys with structured and single-bit patterns and checks every word of every table.

// File: rtl/rc5_mix_pkg.sv
package rc5_mix_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned ROUNDS    = 12;
  localparam int unsigned KEY_BYTES = 16;
  localparam int unsigned S_WORDS   = 2 * ROUNDS + 2;
  localparam int unsigned L_WORDS   = KEY_BYTES / (WORD_W / 8);
  localparam int unsigned ITERS     = 3 * ((S_WORDS > L_WORDS) ? S_WORDS : L_WORDS);
  localparam int unsigned STEP_CLKS = 3;
  localparam int unsigned S_AW      = $clog2(S_WORDS);
  localparam int unsigned L_AW      = $clog2(L_WORDS);
  localparam int unsigned IT_W      = $clog2(ITERS);
  localparam int unsigned ROT_W     = $clog2(WORD_W);
  localparam logic [WORD_W-1:0] SEED_P = 32'hB7E15163;
  localparam logic [WORD_W-1:0] SEED_Q = 32'h9E3779B9;

  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic [1:0] {ST_IDLE, ST_A, ST_B, ST_W} mix_state_e;

  function automatic word_t rotl(input word_t x, input logic [ROT_W-1:0] n);
    logic [2*WORD_W-1:0] t;
    t = {x, x} << n;
    return t[2*WORD_W-1:WORD_W];
  endfunction

  function automatic word_t seed_word(input int unsigned k);
    return SEED_P + word_t'(k) * SEED_Q;
  endfunction
endpackage

// File: rtl/rc5_s_table.sv
module rc5_s_table
  import rc5_mix_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            seed_i,
  input  logic            wr_en_i,
  input  logic [S_AW-1:0] wr_addr_i,
  input  word_t           wr_data_i,
  input  logic [S_AW-1:0] mix_addr_i,
  output word_t           mix_data_o,
  input  logic [S_AW-1:0] rd_addr_i,
  output word_t           rd_data_o
);
  word_t s_q [S_WORDS];

  for (genvar k = 0; k < S_WORDS; k++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        s_q[k] <= seed_word(k);
      else if (seed_i)                                    s_q[k] <= seed_word(k);
      else if (wr_en_i && wr_addr_i == S_AW'(k))          s_q[k] <= wr_data_i;
    end
  end

  always_comb begin
    mix_data_o = '0;
    rd_data_o  = '0;
    for (int k = 0; k < S_WORDS; k++) begin
      if (mix_addr_i == S_AW'(k)) mix_data_o = s_q[k];
      if (rd_addr_i  == S_AW'(k)) rd_data_o  = s_q[k];
    end
  end
endmodule

// File: rtl/rc5_l_regs.sv
module rc5_l_regs
  import rc5_mix_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [8*KEY_BYTES-1:0] key_i,
  input  logic                 wr_en_i,
  input  logic [L_AW-1:0]      addr_i,
  input  word_t                wr_data_i,
  output word_t                rd_data_o
);
  word_t l_q [L_WORDS];

  for (genvar w = 0; w < L_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  l_q[w] <= '0;
      else if (load_i)                              l_q[w] <= key_i[w*WORD_W +: WORD_W];
      else if (wr_en_i && addr_i == L_AW'(w))       l_q[w] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int w = 0; w < L_WORDS; w++)
      if (addr_i == L_AW'(w)) rd_data_o = l_q[w];
  end
endmodule

// File: rtl/rc5_mix_ctrl.sv
module rc5_mix_ctrl
  import rc5_mix_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  output logic            accept_o,
  output logic            do_a_o,
  output logic            do_b_o,
  output logic            do_w_o,
  output logic [S_AW-1:0] i_o,
  output logic [L_AW-1:0] j_o,
  output logic            busy_o,
  output logic            done_o
);
  mix_state_e      state_q;
  logic [IT_W-1:0] it_q;
  logic            last_it;

  assign accept_o = start_i && (state_q == ST_IDLE);
  assign do_a_o   = state_q == ST_A;
  assign do_b_o   = state_q == ST_B;
  assign do_w_o   = state_q == ST_W;
  assign busy_o   = state_q != ST_IDLE;
  assign last_it  = it_q == IT_W'(ITERS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      it_q    <= '0;
      i_o     <= '0;
      j_o     <= '0;
      done_o  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_A;
          it_q    <= '0;
          i_o     <= '0;
          j_o     <= '0;
          done_o  <= 1'b0;
        end
        ST_A: state_q <= ST_B;
        ST_B: state_q <= ST_W;
        ST_W: begin
          i_o  <= (i_o == S_AW'(S_WORDS - 1)) ? '0 : i_o + 1'b1;
          j_o  <= (j_o == L_AW'(L_WORDS - 1)) ? '0 : j_o + 1'b1;
          it_q <= it_q + 1'b1;
          if (last_it) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
          end else begin
            state_q <= ST_A;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rc5_key_mixer.sv
module rc5_key_mixer
  import rc5_mix_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [8*KEY_BYTES-1:0] key_i,
  output logic                   busy_o,
  output logic                   done_o,
  input  logic [S_AW-1:0]        rd_addr_i,
  output logic [WORD_W-1:0]      rd_data_o
);
  logic            accept, do_a, do_b, do_w;
  logic [S_AW-1:0] idx_i;
  logic [L_AW-1:0] idx_j;
  word_t           s_cur, l_cur, a_q, b_q, ab_sum;

  rc5_mix_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .accept_o(accept), .do_a_o(do_a), .do_b_o(do_b), .do_w_o(do_w),
    .i_o(idx_i), .j_o(idx_j), .busy_o, .done_o
  );

  rc5_s_table u_s (
    .clk_i, .rst_ni, .seed_i(accept),
    .wr_en_i(do_w), .wr_addr_i(idx_i), .wr_data_i(a_q),
    .mix_addr_i(idx_i), .mix_data_o(s_cur),
    .rd_addr_i, .rd_data_o
  );

  rc5_l_regs u_l (
    .clk_i, .rst_ni, .load_i(accept), .key_i,
    .wr_en_i(do_w), .addr_i(idx_j), .wr_data_i(b_q), .rd_data_o(l_cur)
  );

  assign ab_sum = a_q + b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (accept) begin
      a_q <= '0;
      b_q <= '0;
    end else if (do_a) begin
      a_q <= rotl(s_cur + ab_sum, ROT_W'(3));
    end else if (do_b) begin
      // a_q already holds the new A here
      b_q <= rotl(l_cur + ab_sum, ab_sum[ROT_W-1:0]);
    end
  end
endmodule

// File: rtl/rc5_key_mixer_chk.sv
module rc5_key_mixer_chk
  import rc5_mix_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            busy_o,
  input logic            done_o,
  input logic [S_AW-1:0] rd_addr_i,
  input logic [WORD_W-1:0] rd_data_o
);
  localparam int unsigned RUN_CLKS = ITERS * STEP_CLKS;
  localparam int unsigned CW = $clog2(RUN_CLKS + 1);
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + 1'b1;
    else             run_cnt <= '0;
  end

  assert_busy_done_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  assert_start_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !done_o));
  assert_run_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && run_cnt == CW'(RUN_CLKS - 1)) |=> (!busy_o && done_o));
  assert_run_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && run_cnt < CW'(RUN_CLKS - 1)) |=> busy_o);
  assert_done_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
  assert_rd_oob_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i >= S_AW'(S_WORDS)) |-> (rd_data_o == '0));
endmodule

bind rc5_key_mixer rc5_key_mixer_chk u_chk (
  .clk_i, .rst_ni, .start_i, .busy_o, .done_o, .rd_addr_i, .rd_data_o
);

// File: tb/rc5_key_mixer_bench.sv
module rc5_key_mixer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 26;
  localparam int RUN = 234;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] key_i = '0;
  logic         busy_o, done_o;
  logic [4:0]   rd_addr_i = '0;
  logic [31:0]  rd_data_o;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] exp_s [NS];

  rc5_key_mixer u_rc5_key_mixer (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    int m = n % 32;
    if (m == 0) return x;
    return (x << m) | (x >> (32 - m));
  endfunction

  task automatic model(input logic [127:0] k);
    logic [31:0] l [4];
    logic [31:0] a = 0, b = 0;
    int i = 0, j = 0;
    exp_s[0] = 32'hB7E15163;
    for (int n = 1; n < NS; n++) exp_s[n] = exp_s[n-1] + 32'h9E3779B9;
    for (int w = 0; w < 4; w++)
      for (int y = 0; y < 4; y++) l[w][8*y +: 8] = k[8*(4*w+y) +: 8];
    for (int t = 0; t < 78; t++) begin
      a = rl(exp_s[i] + a + b, 3);
      exp_s[i] = a;
      b = rl(l[j] + a + b, int'((a + b) & 32'h1f));
      l[j] = b;
      i = (i + 1) % NS;
      j = (j + 1) % 4;
    end
  endtask

  task automatic check_table(input string req);
    for (int a = 0; a < NS; a++) begin
      rd_addr_i = 5'(a);
      #1;
      check(rd_data_o === exp_s[a], req, rd_data_o, exp_s[a]);
    end
  endtask

  // run one key; optionally hit start again mid-run with another key (R7)
  task automatic run_key(input logic [127:0] k, input bit poke, input logic [127:0] k2);
    int bcnt = 0;
    @(negedge clk_i);
    key_i = k; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o === 1'b1 && done_o === 1'b0, "R2/R6 accept", {30'b0, busy_o, done_o}, 32'h2);
    while (busy_o === 1'b1 && bcnt < 1000) begin
      bcnt++;
      if (poke && bcnt == 100) begin key_i = k2; start_i = 1'b1; end
      if (poke && bcnt == 101) start_i = 1'b0;
      @(negedge clk_i);
    end
    check(bcnt == RUN, "R5 busy length", 32'(bcnt), 32'(RUN));
    check(done_o === 1'b1 && busy_o === 1'b0, "R6/R8 done", {30'b0, busy_o, done_o}, 32'h1);
    model(k);
    check_table(poke ? "R7 ignored start" : "R3/R4 table");
    repeat (3) @(negedge clk_i);
    check(done_o === 1'b1, "R6 done held", {31'b0, done_o}, 32'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog R5 actual=%h expected=%h", 32'h0, 32'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] kb;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state and seed table
    check(busy_o === 1'b0 && done_o === 1'b0, "R1 flags", {30'b0, busy_o, done_o}, 32'h0);
    exp_s[0] = 32'hB7E15163;
    for (int n = 1; n < NS; n++) exp_s[n] = exp_s[n-1] + 32'h9E3779B9;
    check_table("R1 seed");
    // R9 out-of-range reads
    for (int a = NS; a < 32; a++) begin
      rd_addr_i = 5'(a);
      #1;
      check(rd_data_o === 32'h0, "R9 oob read", rd_data_o, 32'h0);
    end

    run_key('0, 1'b0, '0);
    run_key({128{1'b1}}, 1'b0, '0);
    for (int b = 0; b < 16; b++) kb[8*b +: 8] = 8'(b);
    run_key(kb, 1'b0, '0); // R2 byte order
    for (int s = 0; s < 128; s += 19) run_key(128'(1) << s, 1'b0, '0);
    for (int v = 1; v < 5; v++) run_key({16{8'(v * 8'h37)}}, 1'b0, '0);
    run_key(128'h0123456789ABCDEF_FEDCBA9876543210, 1'b1, {128{1'b1}});

    // R6 done cleared by a new start
    @(negedge clk_i);
    key_i = '0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(done_o === 1'b0, "R6 done cleared", {31'b0, done_o}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule